// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Flags

An 18-bit first-in first-out buffer with separate write and read ports. Each port has its own clock and enable, and the two clocks may be one clock or unrelated clocks. Storage is a parameterised array of 256, 512, 1024, 2048 or 4096 words. Pointers cross between the two clock domains as Gray codes through two-flop synchronizers. The read-side flags are computed in the read domain and the write-side flags in the write domain.

A mode input picks between two read timings. In standard timing the output only changes when a read is issued. In fall-through timing the head word is moved into the output register automatically. The two status outputs change meaning with the mode: empty/full in standard timing, and output-ready/input-ready in fall-through timing. The block also drives an almost-empty flag, an almost-full flag and a half-full flag. The two almost thresholds are loaded through a load input that steps through the two offset registers.

Top module: `dm_sync_fifo`

## Requirements
- R1: After reset with standard timing selected: `rd_flag_o`=1, `wr_flag_o`=0, `almost_empty_o`=1, `almost_full_o`=0, `half_full_o`=0 and `rd_data_o`=0. After reset with fall-through timing selected: `rd_flag_o`=0 and `wr_flag_o`=1. Both offsets reset to 7.
- R2: Words leave the buffer in the order they were written, with their data unchanged.
- R3: Standard timing. A word written into an empty buffer does not reach `rd_data_o` until a read. `rd_flag_o` (1 = empty) falls after the second read-clock edge that follows the write edge. A read with `rd_en_i`=1 updates `rd_data_o` on its own read-clock edge.
- R4: Fall-through timing. A word written into an empty buffer appears on `rd_data_o`, with `rd_flag_o` (1 = output ready) high, after the third read-clock edge that follows the write edge, with no read enable. The word is held while `rd_en_i`=0. Each read-clock edge with `rd_en_i`=1 while ready presents the next word.
- R5: Standard timing. `wr_flag_o` (1 = full) rises on the write edge that stores the DEPTH-th word. A write while full is ignored and leaves the stored words unchanged.
- R6: A read while `rd_flag_o` shows empty (standard) or not ready (fall-through) is ignored and leaves `rd_data_o` unchanged.
- R7: Fall-through timing. `wr_flag_o` (1 = input ready) falls once DEPTH words sit in storage behind the output word, so DEPTH+1 words in total. A write while it is low is ignored.
- R8: `almost_empty_o` is 1 when the readable word count is at most the almost-empty offset, and 0 otherwise. The readable count is the storage count, plus one for a held output word in fall-through timing.
- R9: `almost_full_o` is 1 when the storage count is at least DEPTH minus the almost-full offset, and 0 otherwise.
- R10: `half_full_o` is 1 when the storage count is greater than DEPTH/2, and 0 otherwise.
- R11: While `ld_i`=1, each write-clock edge with `wr_en_i`=1 stores `wr_data_i[AW-1:0]` into an offset register instead of the buffer. The registers are written alternately, almost-empty first and then almost-full, wrapping back to almost-empty. The sequence restarts at almost-empty whenever `ld_i`=0.
- R12: `fwft_i` is sampled on the first clock edge after reset release in each domain (1 = fall-through). Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| fwft_i | input | 1 | Timing select, sampled after reset (1 = fall-through) |
| wr_en_i | input | 1 | Write enable |
| ld_i | input | 1 | Offset-load select for write-port cycles |
| wr_data_i | input | 18 | Write data, or offset value when loading |
| rd_en_i | input | 1 | Read enable |
| rd_data_o | output | 18 | Output data register |
| rd_flag_o | output | 1 | Empty (standard) / output ready (fall-through) |
| wr_flag_o | output | 1 | Full (standard) / input ready (fall-through) |
| almost_empty_o | output | 1 | Readable count at or below the almost-empty offset |
| almost_full_o | output | 1 | Storage count at or above DEPTH minus the almost-full offset |
| half_full_o | output | 1 | Storage count above DEPTH/2 |

## Verification
Suppose a pointer advances on a write while full, or on a read while empty. The next drain then returns a word that was overwritten, or one that was never written, and the data check fails on that word within one buffer's worth of reads. A synchronizer stage that is missing or added moves the flag and fall-through latencies by one edge, and the bench checks those latencies on an exact edge. A wrong offset sequencer state moves the almost-flag boundary by one or more words, and this shows up at the first count that straddles that boundary.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam int DATA_W      = 18;
  localparam int OFS_DEFAULT = 7;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/fdm_sync.sv
// Two-flop Gray synchronizer with binary decode on the destination side
module fdm_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_dec
    assign bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/fdm_mem.sv
module fdm_mem #(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fdm_wr_ctrl.sv
// Write domain: pointer, full/ready, almost-full, half-full, offset loader
module fdm_wr_ctrl #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wr_en_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ofs_data_i,
  input  logic [AW:0]   rptr_i,
  output logic [AW:0]   wptr_o,
  output logic [AW:0]   wgray_o,
  output logic          we_o,
  output logic [AW:0]   cnt_o,
  output logic          fwft_o,
  output logic          wr_flag_o,
  output logic          almost_full_o,
  output logic          half_full_o,
  output logic [AW-1:0] ae_ofs_o
);
  import fdm_pkg::*;

  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0]   HALF_CNT = (AW+1)'(DEPTH / 2);
  localparam logic [AW-1:0] OFS_RST  = AW'(OFS_DEFAULT);

  logic          init_q, fwft_q;
  logic [AW:0]   wptr_q, wgray_q, wptr_n, cnt, af_thr;
  logic [AW-1:0] ae_q, af_q;
  ofs_sel_e      sel_q;
  logic          full, push;

  assign cnt    = wptr_q - rptr_i;
  assign full   = (cnt == FULL_CNT);
  assign push   = wr_en_i & ~ld_i & ~full;
  assign wptr_n = wptr_q + 1'b1;
  assign af_thr = FULL_CNT - {1'b0, af_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      fwft_q <= 1'b0;
    end else if (init_q) begin
      init_q <= 1'b0;
      fwft_q <= fwft_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wptr_q  <= wptr_n;
      wgray_q <= wptr_n ^ (wptr_n >> 1);
    end
  end

  // Offset loader: alternates AE/AF while ld_i held, restarts when released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_AE;
      ae_q  <= OFS_RST;
      af_q  <= OFS_RST;
    end else if (!ld_i) begin
      sel_q <= SEL_AE;
    end else if (wr_en_i) begin
      if (sel_q == SEL_AE) begin
        ae_q  <= ofs_data_i;
        sel_q <= SEL_AF;
      end else begin
        af_q  <= ofs_data_i;
        sel_q <= SEL_AE;
      end
    end
  end

  assign wptr_o        = wptr_q;
  assign wgray_o       = wgray_q;
  assign we_o          = push;
  assign cnt_o         = cnt;
  assign fwft_o        = fwft_q;
  assign wr_flag_o     = fwft_q ? ~full : full;
  assign almost_full_o = (cnt >= af_thr);
  assign half_full_o   = (cnt > HALF_CNT);
  assign ae_ofs_o      = ae_q;
endmodule

// File: rtl/fdm_rd_ctrl.sv
// Read domain: pointer, output stage, empty/ready, almost-empty
module fdm_rd_ctrl #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          rd_en_i,
  input  logic [AW:0]   wptr_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [AW-1:0] ae_ofs_i,
  output logic [AW:0]   rptr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_flag_o,
  output logic          almost_empty_o,
  output logic          fwft_o
);
  import fdm_pkg::*;

  localparam logic [AW-1:0] OFS_RST = AW'(OFS_DEFAULT);

  logic          init_q, fwft_q, oval_q;
  logic [AW:0]   rptr_q, rgray_q, rptr_n, mem_cnt, avail;
  logic [AW-1:0] ofs_s1_q, ofs_s2_q;
  logic [DW-1:0] dout_q;
  logic          mem_empty, pop;

  assign mem_cnt   = wptr_i - rptr_q;
  assign mem_empty = (mem_cnt == '0);
  assign rptr_n    = rptr_q + 1'b1;
  assign pop       = fwft_q ? (~mem_empty & (~oval_q | rd_en_i))
                            : (rd_en_i & ~mem_empty);
  assign avail     = mem_cnt + {{AW{1'b0}}, fwft_q & oval_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      fwft_q <= 1'b0;
    end else if (init_q) begin
      init_q <= 1'b0;
      fwft_q <= fwft_i;
    end
  end

  // Offset is quasi-static; loaded while idle, settles in two edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_s1_q <= OFS_RST;
      ofs_s2_q <= OFS_RST;
    end else begin
      ofs_s1_q <= ae_ofs_i;
      ofs_s2_q <= ofs_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      oval_q  <= 1'b0;
    end else begin
      if (pop) begin
        rptr_q  <= rptr_n;
        rgray_q <= rptr_n ^ (rptr_n >> 1);
        dout_q  <= rdata_i;
      end
      if (fwft_q) begin
        if (pop)          oval_q <= 1'b1;
        else if (rd_en_i) oval_q <= 1'b0;
      end
    end
  end

  assign rptr_o         = rptr_q;
  assign rgray_o        = rgray_q;
  assign rd_data_o      = dout_q;
  assign rd_flag_o      = fwft_q ? oval_q : mem_empty;
  assign almost_empty_o = (avail <= {1'b0, ofs_s2_q});
  assign fwft_o         = fwft_q;
endmodule

// File: rtl/dm_sync_fifo.sv
module dm_sync_fifo #(
  parameter int DEPTH = 256
) (
  input  logic        wclk_i,
  input  logic        rclk_i,
  input  logic        rst_ni,
  input  logic        fwft_i,
  input  logic        wr_en_i,
  input  logic        ld_i,
  input  logic [17:0] wr_data_i,
  input  logic        rd_en_i,
  output logic [17:0] rd_data_o,
  output logic        rd_flag_o,
  output logic        wr_flag_o,
  output logic        almost_empty_o,
  output logic        almost_full_o,
  output logic        half_full_o
);
  import fdm_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int DW = DATA_W;

  logic [AW:0]   wptr_bin, wptr_gray, wptr_sync;
  logic [AW:0]   rptr_bin, rptr_gray, rptr_sync;
  logic [AW:0]   wcnt;
  logic          we, fwft_w, fwft_r;
  logic [AW-1:0] ae_ofs;
  logic [DW-1:0] mem_rdata;

  fdm_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk_i        (wclk_i),
    .rst_ni       (rst_ni),
    .fwft_i       (fwft_i),
    .wr_en_i      (wr_en_i),
    .ld_i         (ld_i),
    .ofs_data_i   (wr_data_i[AW-1:0]),
    .rptr_i       (rptr_sync),
    .wptr_o       (wptr_bin),
    .wgray_o      (wptr_gray),
    .we_o         (we),
    .cnt_o        (wcnt),
    .fwft_o       (fwft_w),
    .wr_flag_o    (wr_flag_o),
    .almost_full_o(almost_full_o),
    .half_full_o  (half_full_o),
    .ae_ofs_o     (ae_ofs)
  );

  fdm_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(wptr_bin[AW-1:0]),
    .wdata_i(wr_data_i),
    .raddr_i(rptr_bin[AW-1:0]),
    .rdata_o(mem_rdata)
  );

  fdm_sync #(.W(AW+1)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wptr_gray),
    .bin_o (wptr_sync)
  );

  fdm_sync #(.W(AW+1)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .gray_i(rptr_gray),
    .bin_o (rptr_sync)
  );

  fdm_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .clk_i         (rclk_i),
    .rst_ni        (rst_ni),
    .fwft_i        (fwft_i),
    .rd_en_i       (rd_en_i),
    .wptr_i        (wptr_sync),
    .rdata_i       (mem_rdata),
    .ae_ofs_i      (ae_ofs),
    .rptr_o        (rptr_bin),
    .rgray_o       (rptr_gray),
    .rd_data_o     (rd_data_o),
    .rd_flag_o     (rd_flag_o),
    .almost_empty_o(almost_empty_o),
    .fwft_o        (fwft_r)
  );
endmodule

// File: rtl/dm_sync_fifo_chk.sv
module dm_sync_fifo_chk #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        ld_i,
  input logic        rd_en_i,
  input logic [17:0] rd_data_i,
  input logic        rd_flag_i,
  input logic        wr_flag_i,
  input logic        almost_full_i,
  input logic        half_full_i,
  input logic [AW:0] wptr_i,
  input logic [AW:0] rptr_i,
  input logic [AW:0] wcnt_i,
  input logic        fwft_w_i,
  input logic        fwft_r_i
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  p_no_overflow_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wcnt_i == FULL_CNT && wr_en_i) |=> (wptr_i == $past(wptr_i)));

  p_cnt_bound_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wcnt_i <= FULL_CNT);

  p_full_flag_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wcnt_i == FULL_CNT) |-> (wr_flag_i == !fwft_w_i));

  p_full_marks_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wcnt_i == FULL_CNT) |-> (almost_full_i && half_full_i));

  p_load_no_push_r11: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ld_i |=> (wptr_i == $past(wptr_i)));

  p_no_underflow_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_r_i && rd_flag_i && rd_en_i) |=> (rptr_i == $past(rptr_i)));

  p_fwft_hold_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft_r_i && rd_flag_i && !rd_en_i) |=> ($stable(rd_data_i) && rd_flag_i));
endmodule

bind dm_sync_fifo dm_sync_fifo_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .wclk_i       (wclk_i),
  .rclk_i       (rclk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .ld_i         (ld_i),
  .rd_en_i      (rd_en_i),
  .rd_data_i    (rd_data_o),
  .rd_flag_i    (rd_flag_o),
  .wr_flag_i    (wr_flag_o),
  .almost_full_i(almost_full_o),
  .half_full_i  (half_full_o),
  .wptr_i       (wptr_bin),
  .rptr_i       (rptr_bin),
  .wcnt_i       (wcnt),
  .fwft_w_i     (fwft_w),
  .fwft_r_i     (fwft_r)
);

// File: tb/sim_dm_sync_fifo.sv
`timescale 1ns/1ps
module sim_dm_sync_fifo;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_ni, fwft_i, wr_en_i, ld_i, rd_en_i;
  logic [17:0] wr_data_i, rd_data_o;
  logic        rd_flag_o, wr_flag_o, almost_empty_o, almost_full_o, half_full_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dm_sync_fifo #(.DEPTH(DEPTH)) u0 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .fwft_i(fwft_i),
    .wr_en_i(wr_en_i), .ld_i(ld_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .rd_flag_o(rd_flag_o), .wr_flag_o(wr_flag_o),
    .almost_empty_o(almost_empty_o), .almost_full_o(almost_full_o),
    .half_full_o(half_full_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst_ni = 1'b0; fwft_i = mode; wr_en_i = 0; ld_i = 0; rd_en_i = 0; wr_data_i = '0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic push(input logic [17:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    cyc(1);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset_std;
    do_reset(1'b0);
    chk("R1 rd_flag", rd_flag_o, 1);
    chk("R1 wr_flag", wr_flag_o, 0);
    chk("R1 almost_empty", almost_empty_o, 1);
    chk("R1 almost_full", almost_full_o, 0);
    chk("R1 half_full", half_full_o, 0);
    chk("R1 rd_data", rd_data_o, 0);
  endtask

  task automatic t_std_latency;
    do_reset(1'b0);
    wr_en_i = 1'b1; wr_data_i = 18'h1A5A5;
    cyc(1);
    wr_data_i = 18'h02222;
    chk("R3 empty after write edge", rd_flag_o, 1);
    cyc(1);
    wr_data_i = 18'h03333;
    chk("R3 empty after 1st read edge", rd_flag_o, 1);
    cyc(1);
    wr_en_i = 1'b0;
    chk("R3 not empty after 2nd read edge", rd_flag_o, 0);
    chk("R3 no data before read", rd_data_o, 0);
    rd_en_i = 1'b1;
    cyc(1);
    chk("R2 word0", rd_data_o, 18'h1A5A5);
    cyc(1);
    chk("R2 word1", rd_data_o, 18'h02222);
    cyc(1);
    rd_en_i = 1'b0;
    chk("R2 word2", rd_data_o, 18'h03333);
    chk("R3 empty after drain", rd_flag_o, 1);
    rd_en_i = 1'b1;
    cyc(2);
    rd_en_i = 1'b0;
    chk("R6 read on empty keeps data", rd_data_o, 18'h03333);
    chk("R6 still empty", rd_flag_o, 1);
  endtask

  task automatic t_std_full;
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      wr_en_i = 1'b1; wr_data_i = 18'(i);
      cyc(1);
      if (i + 1 == 128) chk("R10 half_full at 128", half_full_o, 0);
      if (i + 1 == 129) chk("R10 half_full at 129", half_full_o, 1);
      if (i + 1 == 248) chk("R9 almost_full at 248", almost_full_o, 0);
      if (i + 1 == 249) chk("R9 almost_full at 249", almost_full_o, 1);
      if (i + 1 == 255) chk("R5 not full at 255", wr_flag_o, 0);
    end
    chk("R5 full at DEPTH", wr_flag_o, 1);
    wr_data_i = 18'h3FFFF;
    cyc(2);
    wr_en_i = 1'b0;
    chk("R5 still full", wr_flag_o, 1);
    cyc(2);
    rd_en_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1);
      if (rd_data_o !== 18'(i)) chk("R5 R2 drain data", rd_data_o, 32'(i));
      if (DEPTH - 1 - i == 8) chk("R8 almost_empty at 8", almost_empty_o, 0);
      if (DEPTH - 1 - i == 7) chk("R8 almost_empty at 7", almost_empty_o, 1);
    end
    rd_en_i = 1'b0;
    chk("R5 last word", rd_data_o, DEPTH - 1);
    chk("R5 empty after drain", rd_flag_o, 1);
    cyc(3);
    chk("R5 full cleared", wr_flag_o, 0);
  endtask

  task automatic t_load;
    do_reset(1'b0);
    ld_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 18'd3;
    cyc(1);
    wr_data_i = 18'd250;
    cyc(1);
    wr_data_i = 18'd4;
    cyc(1);
    ld_i = 1'b0; wr_en_i = 1'b0;
    cyc(3);
    chk("R11 load writes not stored", rd_flag_o, 1);
    for (int i = 0; i < 4; i++) push(18'(i));
    cyc(3);
    chk("R11 R8 ae offset 4, count 4", almost_empty_o, 1);
    chk("R11 R9 af offset 250, count 4", almost_full_o, 0);
    push(18'd4);
    cyc(3);
    chk("R11 R8 ae offset 4, count 5", almost_empty_o, 0);
    chk("R11 R9 af count 5", almost_full_o, 0);
    push(18'd5);
    chk("R11 R9 af count 6", almost_full_o, 1);
  endtask

  task automatic t_fwft;
    do_reset(1'b1);
    fwft_i = 1'b0;
    chk("R1 fwft rd_flag", rd_flag_o, 0);
    chk("R1 fwft wr_flag", wr_flag_o, 1);
    wr_en_i = 1'b1; wr_data_i = 18'h0ABCD;
    cyc(1);
    wr_en_i = 1'b0;
    chk("R4 not ready after write edge", rd_flag_o, 0);
    cyc(1);
    chk("R4 not ready after edge 1", rd_flag_o, 0);
    cyc(1);
    chk("R4 not ready after edge 2", rd_flag_o, 0);
    cyc(1);
    chk("R4 R12 ready after edge 3", rd_flag_o, 1);
    chk("R4 word falls through", rd_data_o, 18'h0ABCD);
    chk("R8 fwft held word counted", almost_empty_o, 1);
    push(18'h00111);
    cyc(4);
    chk("R4 held without read", rd_data_o, 18'h0ABCD);
    rd_en_i = 1'b1;
    cyc(1);
    chk("R4 next word", rd_data_o, 18'h00111);
    cyc(1);
    rd_en_i = 1'b0;
    chk("R4 drained", rd_flag_o, 0);
    rd_en_i = 1'b1;
    cyc(1);
    rd_en_i = 1'b0;
    chk("R6 read while not ready", rd_data_o, 18'h00111);
    for (int i = 0; i <= DEPTH; i++) push(18'(16'h100 + i));
    cyc(5);
    chk("R7 input not ready at DEPTH+1", wr_flag_o, 0);
    push(18'h3FFFF);
    cyc(2);
    rd_en_i = 1'b1;
    for (int i = 0; i <= DEPTH; i++) begin
      if (rd_data_o !== 18'(16'h100 + i) || rd_flag_o !== 1'b1)
        chk("R7 R2 fwft drain", {rd_flag_o, 13'd0, rd_data_o}, {1'b1, 13'd0, 18'(16'h100 + i)});
      cyc(1);
    end
    rd_en_i = 1'b0;
    chk("R7 extra write dropped", rd_flag_o, 0);
    cyc(3);
    chk("R7 input ready again", wr_flag_o, 1);
  endtask

  initial begin
    t_reset_std();
    t_std_latency();
    t_std_full();
    t_load();
    t_fwft();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule